// File: doc/BRIEF.md
# I2C Bus Idle and Hang Watchdog

This block watches the SCL and SDA lines of a local I2C bus, which reach it already synchronised to the system clock, and measures how long the bus has been quiet. A change on either line restarts the measurement. Time advances only on cycles where the system tick input is high. A speed-up input selects between a long timeout, normally set near one second, and a short one, normally near fifty milliseconds. A disable input stops the timer from ever expiring. Both timeouts are parameters counted in ticks, so a simulation can use small values.

When the timeout expires with SDA high, the block raises a bus-free flag. The next START condition seen on the bus clears that flag again. When the timeout expires with SDA low, the bus is taken to be hung. The block then pulls SCL low and releases it in timed pulses, up to a parameterised maximum. It stops pulsing as soon as it samples SDA high. It then produces a STOP condition by driving both lines and releasing them in order. A one-cycle done pulse marks the end of recovery, and idle timing then starts again.

The drive outputs are open-drain enables: a high output means the pad pulls the line low. The pads and the I2C transaction engine lie outside this block.

Top module: `i2c_idle_watchdog`

## Requirements
- R1: While rst_ni is low, bus_free_o, scl_drive_low_o, sda_drive_low_o and recovery_done_o are all 0.
- R2: With disable_i = 0 and speedup_i = 0, once LONG_TICKS ticks pass with no line edge and SDA is high at the last of them, bus_free_o goes to 1 on that tick's clock edge and stays at 1 until cleared.
- R3: With speedup_i = 1, the same expiry happens after SHORT_TICKS ticks instead of LONG_TICKS.
- R4: While disable_i = 1, the idle count is held at zero, so the block neither sets bus_free_o nor starts recovery, whatever the line levels.
- R5: Any change of scl_i or sda_i from its value at the previous clock edge restarts the idle count from zero.
- R6: A START condition clears bus_free_o on the next clock edge. A START is SDA going from 1 to 0 while SCL is 1 at both samples.
- R7: An expiry with sda_i = 0 starts recovery and clears bus_free_o. Each recovery pulse holds scl_drive_low_o at 1 for PHASE_TICKS ticks and then at 0 for PHASE_TICKS ticks.
- R8: At the end of each released-SCL phase, sda_i is sampled. If it is 1, or if MAX_PULSES pulses have been issued, pulsing stops. No recovery issues more than MAX_PULSES pulses.
- R9: After pulsing, a STOP condition is produced in two phases. First both drive outputs are 1 for PHASE_TICKS ticks. Then only sda_drive_low_o is 1 for PHASE_TICKS ticks. After that both drives release, recovery_done_o is 1 for exactly one cycle, and idle timing restarts.
- R10: Only clock cycles with tick_i = 1 advance the idle count and the recovery phase count.
- R11: bus_free_o is 0 in every cycle in which either drive output is 1, and the drive outputs are 1 only during recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base enable; one timer step per high cycle |
| scl_i | input | 1 | Synchronised SCL line level |
| sda_i | input | 1 | Synchronised SDA line level |
| speedup_i | input | 1 | 1 selects the short timeout |
| disable_i | input | 1 | 1 prevents any expiry |
| bus_free_o | output | 1 | Bus declared idle and free |
| scl_drive_low_o | output | 1 | Enable for pulling SCL low |
| sda_drive_low_o | output | 1 | Enable for pulling SDA low (STOP generation) |
| recovery_done_o | output | 1 | One-cycle pulse when recovery finishes |

## Verification
The bench measures the exact number of cycles from the last line edge to bus-free, for both timeouts and with a sparse tick. An off-by-one timer, a design that ignores the speed-up selection, or one that counts every clock would each show a different count. A modelled slave holds SDA low and lets it go after three SCL rises. A design that samples SDA at the wrong moment or ignores it would issue the wrong number of pulses. A slave that never lets go checks that pulsing stops at the limit rather than running on. A START raised on a free bus, and a disabled timer with SDA held low, check that the flag clears and that a disabled block never pulls a line.

// File: rtl/i2c_wd_pkg.sv
package i2c_wd_pkg;
  typedef enum logic [2:0] {
    WD_MON,
    WD_PULSE_LO,
    WD_PULSE_HI,
    WD_STOP_LO,
    WD_STOP_HI
  } wd_state_e;
endpackage

// File: rtl/i2c_wd_edge.sv
module i2c_wd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic activity_o,
  output logic start_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign activity_o = (scl_i ^ scl_q) | (sda_i ^ sda_q);
  assign start_o    = scl_q & scl_i & sda_q & ~sda_i;
endmodule

// File: rtl/i2c_wd_timer.sv
module i2c_wd_timer #(
  parameter int LONG_TICKS  = 1000,
  parameter int SHORT_TICKS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  input  logic speedup_i,
  output logic expire_o
);
  localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             at_last;

  assign last     = speedup_i ? SHORT_LAST : LONG_LAST;
  assign at_last  = (cnt_q >= last);
  assign expire_o = ~clear_i & tick_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i)            cnt_q <= '0;
    else if (tick_i && at_last)  cnt_q <= '0;
    else if (tick_i)             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_wd_recover.sv
module i2c_wd_recover
  import i2c_wd_pkg::*;
#(
  parameter int PHASE_TICKS = 5,
  parameter int MAX_PULSES  = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic sda_i,
  output logic busy_o,
  output logic scl_drv_o,
  output logic sda_drv_o,
  output logic done_o
);
  localparam int PH_W = $clog2(PHASE_TICKS + 1);
  localparam int NP_W = $clog2(MAX_PULSES + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASE_TICKS - 1);
  localparam logic [NP_W-1:0] NP_LAST = NP_W'(MAX_PULSES - 1);

  wd_state_e       state_q;
  logic [PH_W-1:0] ph_q;
  logic [NP_W-1:0] np_q;
  logic            ph_end;

  assign ph_end = tick_i & (ph_q == PH_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_MON;
      ph_q    <= '0;
      np_q    <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (state_q == WD_MON) begin
        if (start_i) begin
          state_q <= WD_PULSE_LO;
          ph_q    <= '0;
          np_q    <= '0;
        end
      end else if (ph_end) begin
        ph_q <= '0;
        unique case (state_q)
          WD_PULSE_LO: state_q <= WD_PULSE_HI;
          WD_PULSE_HI: begin
            np_q    <= np_q + 1'b1;
            state_q <= (sda_i || np_q == NP_LAST) ? WD_STOP_LO : WD_PULSE_LO;
          end
          WD_STOP_LO:  state_q <= WD_STOP_HI;
          WD_STOP_HI: begin
            state_q <= WD_MON;
            done_o  <= 1'b1;
          end
          default:     state_q <= WD_MON;
        endcase
      end else if (tick_i) begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign busy_o    = (state_q != WD_MON);
  assign scl_drv_o = (state_q == WD_PULSE_LO) | (state_q == WD_STOP_LO);
  assign sda_drv_o = (state_q == WD_STOP_LO)  | (state_q == WD_STOP_HI);
endmodule

// File: rtl/i2c_idle_watchdog.sv
module i2c_idle_watchdog #(
  parameter int LONG_TICKS  = 1000,
  parameter int SHORT_TICKS = 50,
  parameter int PHASE_TICKS = 5,
  parameter int MAX_PULSES  = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic speedup_i,
  input  logic disable_i,
  output logic bus_free_o,
  output logic scl_drive_low_o,
  output logic sda_drive_low_o,
  output logic recovery_done_o
);
  logic activity, start_cond, expire, rec_busy, rec_start, timer_clear;

  i2c_wd_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .activity_o (activity),
    .start_o    (start_cond)
  );

  // own recovery edges must not count as bus activity
  assign timer_clear = activity | disable_i | rec_busy;

  i2c_wd_timer #(
    .LONG_TICKS  (LONG_TICKS),
    .SHORT_TICKS (SHORT_TICKS)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .clear_i   (timer_clear),
    .speedup_i (speedup_i),
    .expire_o  (expire)
  );

  assign rec_start = expire & ~sda_i;

  i2c_wd_recover #(
    .PHASE_TICKS (PHASE_TICKS),
    .MAX_PULSES  (MAX_PULSES)
  ) u_rec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .start_i   (rec_start),
    .sda_i     (sda_i),
    .busy_o    (rec_busy),
    .scl_drv_o (scl_drive_low_o),
    .sda_drv_o (sda_drive_low_o),
    .done_o    (recovery_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      bus_free_o <= 1'b0;
    else if (expire && sda_i)         bus_free_o <= 1'b1;
    else if (start_cond || rec_start) bus_free_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_wd_checker.sv
module i2c_wd_checker #(
  parameter int MAX_PULSES = 9
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_i,
  input logic disable_i,
  input logic bus_free_o,
  input logic scl_drive_low_o,
  input logic sda_drive_low_o,
  input logic recovery_done_o
);
  int   pulse_cnt;
  logic scl_drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_cnt <= 0;
      scl_drv_q <= 1'b0;
    end else begin
      scl_drv_q <= scl_drive_low_o;
      if (recovery_done_o)
        pulse_cnt <= 0;
      else if (scl_drive_low_o && !scl_drv_q && !sda_drive_low_o)
        pulse_cnt <= pulse_cnt + 1;
    end
  end

  p_start_clears_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(scl_i) && scl_i && $past(sda_i) && !sda_i) |=> !bus_free_o);

  p_free_low_in_rec_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_drive_low_o || sda_drive_low_o) |-> !bus_free_o);

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recovery_done_o |=> !recovery_done_o);

  p_done_after_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recovery_done_o |-> ($past(sda_drive_low_o) && !$past(scl_drive_low_o)));

  p_no_expiry_when_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_free_o) |-> !$past(disable_i));

  p_pulse_needs_low_sda_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(scl_drive_low_o) && !sda_drive_low_o) |-> !$past(sda_i));

  p_pulse_limit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_cnt <= MAX_PULSES);
endmodule

bind i2c_idle_watchdog i2c_wd_checker #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .scl_i           (scl_i),
  .sda_i           (sda_i),
  .disable_i       (disable_i),
  .bus_free_o      (bus_free_o),
  .scl_drive_low_o (scl_drive_low_o),
  .sda_drive_low_o (sda_drive_low_o),
  .recovery_done_o (recovery_done_o)
);

// File: tb/i2c_idle_watchdog_tb.sv
`timescale 1ns/1ps
module i2c_idle_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 40;
  localparam int S  = 12;
  localparam int PH = 3;
  localparam int MP = 9;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b1;
  logic speedup_i = 1'b0;
  logic disable_i = 1'b0;
  logic scl_ext = 1'b1;
  logic sda_ext = 1'b1;
  logic scl_line, sda_line;
  logic bus_free_o, scl_drive_low_o, sda_drive_low_o, recovery_done_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = scl_ext & ~scl_drive_low_o;
  assign sda_line = sda_ext & ~sda_drive_low_o;

  i2c_idle_watchdog #(
    .LONG_TICKS(L), .SHORT_TICKS(S), .PHASE_TICKS(PH), .MAX_PULSES(MP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .scl_i(scl_line), .sda_i(sda_line),
    .speedup_i(speedup_i), .disable_i(disable_i),
    .bus_free_o(bus_free_o), .scl_drive_low_o(scl_drive_low_o),
    .sda_drive_low_o(sda_drive_low_o), .recovery_done_o(recovery_done_o)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int tick_div = 1;
  int all_cyc = 0;
  bit finished = 0;

  // slave model that holds SDA low
  bit slave_mode = 0;
  bit slave_hold = 0;
  int release_after = 0;
  int rises = 0;
  logic slave_prev_scl = 1'b1;

  // observation counters
  int pulses = 0;
  int done_seen = 0;
  int sda_drv_seen = 0;
  logic prev_scl_drv = 1'b0;

  // reference model state
  int   m_st = 0, m_cnt = 0, m_ph = 0, m_np = 0;
  logic m_free = 0, m_done = 0, m_pscl = 1, m_psda = 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    cyc++;
    tick_i = ((cyc % tick_div) == 0);
    if (slave_mode) begin
      if (slave_hold && scl_line && !slave_prev_scl) begin
        rises++;
        if (rises >= release_after) slave_hold = 0;
      end
      sda_ext = !slave_hold;
    end
    slave_prev_scl = scl_line;
  endtask

  task automatic wait_free(input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      step();
      @(negedge clk);
      n++;
      if (bus_free_o) break;
    end
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      step();
      if (done_seen > 0 && !scl_drive_low_o && !sda_drive_low_o) break;
    end
  endtask

  // START then return to idle; returns with last edge just applied
  task automatic start_then_stop();
    sda_ext = 0; step();
    chk(bus_free_o == 0, "R6 start clears bus_free", bus_free_o, 0);
    scl_ext = 0; step();
    step();
    scl_ext = 1; step();
    sda_ext = 1;
  endtask

  // per-cycle reference comparison and model update
  always @(negedge clk) begin
    all_cyc++;
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_ph = 0; m_np = 0;
      m_free = 0; m_done = 0; m_pscl = 1; m_psda = 1;
      prev_scl_drv = 0;
    end else if (!finished) begin
      chk(bus_free_o == m_free, "R2 bus_free vs model", bus_free_o, m_free);
      chk(scl_drive_low_o == (m_st == 1 || m_st == 3), "R7 scl drive vs model",
          scl_drive_low_o, (m_st == 1 || m_st == 3));
      chk(sda_drive_low_o == (m_st == 3 || m_st == 4), "R9 sda drive vs model",
          sda_drive_low_o, (m_st == 3 || m_st == 4));
      chk(recovery_done_o == m_done, "R9 done vs model", recovery_done_o, m_done);
      if (scl_drive_low_o || sda_drive_low_o)
        chk(!bus_free_o, "R11 free low during recovery", bus_free_o, 0);
      if (scl_drive_low_o && !prev_scl_drv && !sda_drive_low_o) pulses++;
      if (recovery_done_o) done_seen++;
      if (sda_drive_low_o) sda_drv_seen++;
      prev_scl_drv = scl_drive_low_o;
      begin
        logic a, st;
        int lim;
        a  = (scl_line != m_pscl) || (sda_line != m_psda);
        st = m_pscl && scl_line && m_psda && !sda_line;
        m_done = 0;
        if (m_st == 0) begin
          lim = speedup_i ? S : L;
          if (a || disable_i) m_cnt = 0;
          else if (tick_i) begin
            if (m_cnt >= lim - 1) begin
              m_cnt = 0;
              if (sda_line) m_free = 1;
              else begin m_free = 0; m_st = 1; m_ph = 0; m_np = 0; end
            end else m_cnt++;
          end
          if (st) m_free = 0;
        end else if (tick_i) begin
          if (m_ph == PH - 1) begin
            m_ph = 0;
            case (m_st)
              1: m_st = 2;
              2: begin m_np++; m_st = (sda_line || m_np == MP) ? 3 : 1; end
              3: m_st = 4;
              default: begin m_st = 0; m_done = 1; end
            endcase
          end else m_ph++;
        end
        m_pscl = scl_line;
        m_psda = sda_line;
      end
    end
  end

  // watchdog
  always @(negedge clk) begin
    if (all_cyc > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=0", all_cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) step();
    @(negedge clk);
    chk(bus_free_o == 0, "R1 reset bus_free", bus_free_o, 0);
    chk(scl_drive_low_o == 0, "R1 reset scl drive", scl_drive_low_o, 0);
    chk(sda_drive_low_o == 0, "R1 reset sda drive", sda_drive_low_o, 0);
    chk(recovery_done_o == 0, "R1 reset done", recovery_done_o, 0);
    @(posedge clk); #1;
    rst_ni = 1;

    // R2: long timeout from reset
    wait_free(3 * L, n);
    chk(n == L, "R2 long timeout cycles", n, L);
    repeat (5) step();
    chk(bus_free_o == 1, "R2 bus_free holds", bus_free_o, 1);

    // R5: edges restart the timer
    start_then_stop();
    repeat (L / 2) step();
    scl_ext = 0; step();
    scl_ext = 1;
    repeat (L - 4) step();
    chk(bus_free_o == 0, "R5 edge restarted timer", bus_free_o, 0);
    sda_ext = 0; step(); sda_ext = 1; step();
    scl_ext = 0; step(); scl_ext = 1;
    wait_free(3 * L, n);
    chk(n == L + 1, "R5 timeout from last edge", n, L + 1);

    // R3: short timeout
    speedup_i = 1;
    start_then_stop();
    wait_free(3 * L, n);
    chk(n == S + 1, "R3 short timeout cycles", n, S + 1);
    speedup_i = 0;

    // R10: sparse tick
    tick_div = 3;
    start_then_stop();
    wait_free(5 * L, n);
    chk(n >= 3 * L && n <= 3 * L + 3, "R10 ticks gate timer", n, 3 * L);
    tick_div = 1;

    // R4: disable, SDA high then low
    disable_i = 1;
    start_then_stop();
    repeat (3 * L) step();
    chk(bus_free_o == 0, "R4 no free while disabled", bus_free_o, 0);
    pulses = 0;
    sda_ext = 0;
    repeat (3 * L) step();
    chk(scl_drive_low_o == 0 && pulses == 0, "R4 no recovery while disabled", pulses, 0);
    sda_ext = 1; step();
    disable_i = 0;
    repeat (3) step();

    // R7/R8/R9: slave releases after three rises
    pulses = 0; done_seen = 0; sda_drv_seen = 0;
    rises = 0; release_after = 3; slave_hold = 1; slave_mode = 1;
    step();
    wait_done(20 * L);
    chk(pulses == 3, "R8 stops when SDA high", pulses, 3);
    chk(done_seen == 1, "R9 one done pulse", done_seen, 1);
    chk(sda_drv_seen == 2 * PH, "R9 stop drives SDA", sda_drv_seen, 2 * PH);
    chk(bus_free_o == 0, "R7 free cleared by recovery", bus_free_o, 0);
    slave_mode = 0; sda_ext = 1;
    wait_free(3 * L, n);
    chk(bus_free_o == 1, "R2 free after recovery", bus_free_o, 1);

    // R8: stuck slave, pulse limit
    pulses = 0; done_seen = 0;
    rises = 0; release_after = 1000; slave_hold = 1; slave_mode = 1;
    step();
    wait_done(40 * L);
    chk(pulses == MP, "R8 pulse limit", pulses, MP);
    chk(done_seen == 1, "R9 done after limit", done_seen, 1);
    slave_mode = 0; sda_ext = 1;
    repeat (L + 5) step();
    chk(bus_free_o == 1, "R2 free after release", bus_free_o, 1);

    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule